// File: doc/BRIEF.md
# Center-Aligned PWM Carrier with Buffered Compares

This block generates a triangular carrier. A counter climbs from zero to a programmable period value and then falls back to zero. One full carrier cycle therefore takes twice the period value in enabled count ticks. The block reports both turning points as single-cycle pulses: the valley pulse at the bottom and the peak pulse at the top. It also drives a set of PWM flip-flops. Each flip-flop is set when the carrier crosses its duty compare value while rising, and cleared when the carrier crosses that value while falling.

All compare registers are loaded from buffer registers that software may write at any time. New values take effect only at defined carrier events, so a cycle that is already running is never disturbed. The period buffer always loads at the valley. A mode input controls the duty buffers:
- In symmetric mode they load once per cycle, at the valley, which gives a waveform mirrored about the peak.
- In asymmetric mode they also load at the peak, so the rising and falling halves can have different duties.

Top module: `cpwm_carrier`

## Requirements
- R1: On each enabled tick the counter steps by one: up while rising, down while falling. The count never exceeds the active period compare value.
- R2: An enabled tick at count 0 while falling is a valley event. In the next cycle `valley_pulse` is 1 and, if the new period is non-zero, the count is 1 and rising.
- R3: An enabled tick at count equal to the period compare while rising is a peak event. In the next cycle `peak_pulse` is 1, the carrier is falling and the count is period-1. There is exactly one peak pulse per carrier cycle.
- R4: With the enable held high, consecutive valley pulses are 2*P cycles apart, where P is the active period.
- R5: The period buffer is copied into the period compare register only on a valley event. A write made mid-cycle leaves the current cycle length unchanged.
- R6: With `mode_asym` = 1, every duty buffer is copied into its compare register on both valley and peak events. A duty-buffer write made after a valley, with rising value X and falling value Y, gives a high time of (P-X)+(P-Y) cycles in that carrier cycle.
- R7: With `mode_asym` = 0, duty buffers are copied only on valley events. High time per cycle is 2*(P-D) for duty value D.
- R8: On an enabled tick where the count equals a channel's compare value, that channel's `pwm_out` bit becomes 1 if rising and 0 if falling. The change is visible in the next cycle.
- R9: After reset the count is 0, the carrier is positioned at a valley (falling state), and pulses, PWM outputs, buffers and compares are 0. The first enabled tick is a valley event and loads all buffers.
- R10: While `cnt_en` is 0 the count, direction, PWM outputs and compares hold, and neither pulse is raised. Pulses last one cycle unless the period is 0.
- R11: A buffer write in the same cycle as a transfer event is not transferred by that event. The previous buffer content is, and the new value moves at the next transfer event.
- R12: If a period of 0 is loaded, the counter holds at 0 in the falling state and a valley event occurs on every enabled tick until a non-zero period is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-clock enable; one enabled cycle is one tick |
| mode_asym | input | 1 | 1: duty buffers reload at valley and peak; 0: valley only |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_wdata | input | CNT_W | Period buffer write data |
| duty_wr | input | NUM_CH | One write strobe per duty buffer |
| duty_wdata | input | CNT_W | Shared duty buffer write data |
| valley_pulse | output | 1 | Registered valley (underflow) event pulse |
| peak_pulse | output | 1 | Registered peak (period match) event pulse |
| pwm_out | output | NUM_CH | PWM flip-flop outputs |
| cnt_out | output | CNT_W | Current carrier count |

## Verification
The bound checker watches the carrier continuously:
- the count stays within the period;
- a rising step adds exactly one;
- each pulse lands on the expected count and direction;
- the period compare changes only with a valley;
- a disabled tick freezes the count.

The reload timing of the duty buffers, and how it depends on the mode, can be shown only by the scenarios in the bench. These include same-cycle write collisions with a transfer, the asymmetric high time produced by a mid-cycle duty write, and the zero-period hold. In those scenarios a reference model and measured high times per cycle are compared against the requirement formulas.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic valley;
    logic peak;
  } carrier_evt_t;

endpackage

// File: rtl/cpwm_tri_counter.sv
module cpwm_tri_counter
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] cnt,
  output dir_e             dir,
  output logic [CNT_W-1:0] per_cmp,
  output carrier_evt_t     hit,
  output logic             valley_pulse,
  output logic             peak_pulse
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] per_buf;

  // turning-point detection on the tick that leaves the extreme
  always_comb begin
    hit.valley = tick && (dir == DIR_DOWN) && (cnt == ZERO);
    hit.peak   = tick && (dir == DIR_UP) && (cnt == per_cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= ZERO;
      dir          <= DIR_DOWN;
      per_cmp      <= ZERO;
      per_buf      <= ZERO;
      valley_pulse <= 1'b0;
      peak_pulse   <= 1'b0;
    end else begin
      valley_pulse <= hit.valley;
      peak_pulse   <= hit.peak;
      if (per_wr) begin
        per_buf <= per_wdata;
      end
      if (hit.valley) begin
        per_cmp <= per_buf;
        if (per_buf != ZERO) begin
          cnt <= ONE;
          dir <= DIR_UP;
        end
      end else if (hit.peak) begin
        cnt <= cnt - ONE;
        dir <= DIR_DOWN;
      end else if (tick) begin
        cnt <= (dir == DIR_UP) ? cnt + ONE : cnt - ONE;
      end
    end
  end

endmodule

// File: rtl/cpwm_reload_sel.sv
module cpwm_reload_sel
  import cpwm_pkg::*;
(
  input  carrier_evt_t hit,
  input  logic         mode_asym,
  output logic         duty_load
);

  always_comb begin
    duty_load = hit.valley | (mode_asym & hit.peak);
  end

endmodule

// File: rtl/cpwm_duty_ch.sv
module cpwm_duty_ch
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  dir_e             dir,
  input  logic [CNT_W-1:0] cnt,
  input  logic             load,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cmp,
  output logic             pwm
);

  logic [CNT_W-1:0] buf_q;
  logic             match;

  always_comb begin
    match = tick && (cnt == cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      cmp   <= '0;
      pwm   <= 1'b0;
    end else begin
      if (load) begin
        cmp <= buf_q;
      end
      if (wr) begin
        buf_q <= wdata;
      end
      if (match) begin
        pwm <= (dir == DIR_UP);
      end
    end
  end

endmodule

// File: rtl/cpwm_carrier.sv
module cpwm_carrier
  import cpwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              mode_asym,
  input  logic              per_wr,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic [NUM_CH-1:0] duty_wr,
  input  logic [CNT_W-1:0]  duty_wdata,
  output logic              valley_pulse,
  output logic              peak_pulse,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [CNT_W-1:0]  cnt_out
);

  logic [CNT_W-1:0] cnt;
  dir_e             cnt_dir;
  logic [CNT_W-1:0] per_cmp;
  carrier_evt_t     hit;
  logic             duty_load;
  logic [CNT_W-1:0] duty_cmp [NUM_CH];

  cpwm_tri_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .tick         (cnt_en),
    .per_wr       (per_wr),
    .per_wdata    (per_wdata),
    .cnt          (cnt),
    .dir          (cnt_dir),
    .per_cmp      (per_cmp),
    .hit          (hit),
    .valley_pulse (valley_pulse),
    .peak_pulse   (peak_pulse)
  );

  cpwm_reload_sel u_rsel (
    .hit       (hit),
    .mode_asym (mode_asym),
    .duty_load (duty_load)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    cpwm_duty_ch #(.CNT_W(CNT_W)) u_duty (
      .clk   (clk),
      .rst   (rst),
      .tick  (cnt_en),
      .dir   (cnt_dir),
      .cnt   (cnt),
      .load  (duty_load),
      .wr    (duty_wr[ch]),
      .wdata (duty_wdata),
      .cmp   (duty_cmp[ch]),
      .pwm   (pwm_out[ch])
    );
  end

  assign cnt_out = cnt;

endmodule

// File: rtl/cpwm_carrier_chk.sv
module cpwm_carrier_chk
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             valley_pulse,
  input logic             peak_pulse,
  input logic [CNT_W-1:0] cnt_out,
  input dir_e             cnt_dir,
  input logic [CNT_W-1:0] per_cmp
);

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_out <= per_cmp);

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_dir == DIR_UP && cnt_out != per_cmp)
      |=> (cnt_out == $past(cnt_out) + 1'b1));

  // R2
  valley_place_chk: assert property (@(posedge clk) disable iff (rst)
    valley_pulse |-> ((cnt_out == CNT_W'(1) && cnt_dir == DIR_UP) ||
                      (cnt_out == '0 && per_cmp == '0)));

  // R3
  peak_place_chk: assert property (@(posedge clk) disable iff (rst)
    peak_pulse |-> (cnt_dir == DIR_DOWN && cnt_out == per_cmp - 1'b1));

  // R3
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(valley_pulse && peak_pulse));

  // R5
  per_reload_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(per_cmp) |-> valley_pulse);

  // R10
  peak_single_chk: assert property (@(posedge clk) disable iff (rst)
    peak_pulse |=> !peak_pulse);

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> ($stable(cnt_out) && !valley_pulse && !peak_pulse));

endmodule

bind cpwm_carrier cpwm_carrier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cnt_en       (cnt_en),
  .valley_pulse (valley_pulse),
  .peak_pulse   (peak_pulse),
  .cnt_out      (cnt_out),
  .cnt_dir      (cnt_dir),
  .per_cmp      (per_cmp)
);

// File: tb/cpwm_carrier_tb.sv
module cpwm_carrier_tb;

  localparam int W   = 16;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cnt_en = 1'b0;
  logic           mode_asym = 1'b0;
  logic           per_wr = 1'b0;
  logic [W-1:0]   per_wdata = '0;
  logic [NCH-1:0] duty_wr = '0;
  logic [W-1:0]   duty_wdata = '0;
  logic           valley_pulse;
  logic           peak_pulse;
  logic [NCH-1:0] pwm_out;
  logic [W-1:0]   cnt_out;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cpwm_carrier #(.CNT_W(W), .NUM_CH(NCH)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .cnt_en       (cnt_en),
    .mode_asym    (mode_asym),
    .per_wr       (per_wr),
    .per_wdata    (per_wdata),
    .duty_wr      (duty_wr),
    .duty_wdata   (duty_wdata),
    .valley_pulse (valley_pulse),
    .peak_pulse   (peak_pulse),
    .pwm_out      (pwm_out),
    .cnt_out      (cnt_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- scoreboard: reference model pushes, monitor pops
  typedef struct packed {
    logic [W-1:0]   cnt;
    logic           v;
    logic           p;
    logic [NCH-1:0] pwm;
  } exp_t;

  exp_t sbq[$];

  logic [W-1:0]   m_cnt = '0;
  logic           m_up = 1'b0;
  logic [W-1:0]   m_per = '0;
  logic [W-1:0]   m_pbuf = '0;
  logic [W-1:0]   m_dbuf [NCH];
  logic [W-1:0]   m_dcmp [NCH];
  logic [NCH-1:0] m_pwm = '0;
  logic           mv;
  logic           mp;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = '0; m_up = 1'b0; m_per = '0; m_pbuf = '0; m_pwm = '0;
      for (int i = 0; i < NCH; i++) begin
        m_dbuf[i] = '0;
        m_dcmp[i] = '0;
      end
    end else begin
      mv = cnt_en && !m_up && (m_cnt == '0);
      mp = cnt_en && m_up && (m_cnt == m_per);
      for (int i = 0; i < NCH; i++) begin
        if (cnt_en && m_cnt == m_dcmp[i]) m_pwm[i] = m_up;
        if (mv || (mode_asym && mp)) m_dcmp[i] = m_dbuf[i];
        if (duty_wr[i]) m_dbuf[i] = duty_wdata;
      end
      if (cnt_en) begin
        if (mv) begin
          m_per = m_pbuf;
          if (m_pbuf != '0) begin
            m_cnt = 1;
            m_up  = 1'b1;
          end
        end else if (mp) begin
          m_up  = 1'b0;
          m_cnt = m_cnt - 1'b1;
        end else if (m_up) begin
          m_cnt = m_cnt + 1'b1;
        end else begin
          m_cnt = m_cnt - 1'b1;
        end
      end
      if (per_wr) m_pbuf = per_wdata;
      sbq.push_back('{cnt: m_cnt, v: mv, p: mp, pwm: m_pwm});
    end
  end

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk(cnt_out == e.cnt, "R1", "count", cnt_out, e.cnt);
      chk(valley_pulse == e.v, "R2", "valley pulse", valley_pulse, e.v);
      chk(peak_pulse == e.p, "R3", "peak pulse", peak_pulse, e.p);
      chk(pwm_out == e.pwm, "R8", "pwm outputs", pwm_out, e.pwm);
    end
  end

  // ---------------- driver helpers
  task automatic wr_per(input logic [W-1:0] v);
    per_wr = 1'b1; per_wdata = v;
    @(negedge clk);
    per_wr = 1'b0;
  endtask

  task automatic wr_duty(input int ch, input logic [W-1:0] v);
    duty_wr = '0; duty_wr[ch] = 1'b1; duty_wdata = v;
    @(negedge clk);
    duty_wr = '0;
  endtask

  // measures one carrier cycle starting at a valley-pulse negedge
  task automatic window(output int n, output int hi [NCH], output int np);
    n = 0; np = 0;
    for (int i = 0; i < NCH; i++) hi[i] = 0;
    do begin
      for (int i = 0; i < NCH; i++) hi[i] += int'(pwm_out[i]);
      np += int'(peak_pulse);
      n++;
      @(negedge clk);
      per_wr  = 1'b0;
      duty_wr = '0;
    end while (!valley_pulse);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n, np;
    int hi [NCH];
    logic [W-1:0]   c0;
    logic [NCH-1:0] p0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk(cnt_out == 0, "R9", "reset count", cnt_out, 0);
    chk(!valley_pulse && !peak_pulse, "R9", "reset pulses", {valley_pulse, peak_pulse}, 0);
    chk(pwm_out == 0, "R9", "reset pwm", pwm_out, 0);

    wr_per(4);
    wr_duty(0, 1);
    wr_duty(1, 2);
    wr_duty(2, 3);
    // R10 nothing moves while disabled
    chk(cnt_out == 0 && !valley_pulse, "R10", "idle while disabled", cnt_out, 0);

    cnt_en = 1'b1;
    @(negedge clk);
    // R9 first enabled tick is a valley that loads the buffers
    chk(valley_pulse && cnt_out == 1, "R9", "first tick valley", cnt_out, 1);

    window(n, hi, np);
    chk(n == 8, "R4", "cycle length P=4", n, 8);
    chk(np == 1, "R3", "one peak per cycle", np, 1);
    chk(hi[0] == 6, "R8", "ch0 high time", hi[0], 6);
    chk(hi[1] == 4, "R8", "ch1 high time", hi[1], 4);
    chk(hi[2] == 2, "R8", "ch2 high time", hi[2], 2);

    // R5 mid-cycle period write does not stretch the running cycle
    per_wr = 1'b1; per_wdata = 8;
    window(n, hi, np);
    chk(n == 8, "R5", "running cycle kept", n, 8);
    window(n, hi, np);
    chk(n == 16, "R5", "new period after valley", n, 16);
    chk(hi[0] == 14 && hi[2] == 10, "R8", "high times P=8", hi[0], 14);

    // R7 symmetric: a duty write lands only at the next valley
    duty_wr = 3'b001; duty_wdata = 2;
    window(n, hi, np);
    chk(hi[0] == 14, "R7", "old duty kept this cycle", hi[0], 14);
    duty_wr = 3'b001; duty_wdata = 5;
    window(n, hi, np);
    chk(hi[0] == 12, "R7", "no reload at peak", hi[0], 12);

    // R6 asymmetric: rising half uses 5, falling half uses 2
    mode_asym = 1'b1;
    duty_wr = 3'b001; duty_wdata = 2;
    window(n, hi, np);
    chk(hi[0] == 9, "R6", "asymmetric high time", hi[0], 9);

    // R11 period write coinciding with the valley tick
    do @(negedge clk); while (cnt_out != 0);
    per_wr = 1'b1; per_wdata = 5;
    @(negedge clk);
    per_wr = 1'b0;
    chk(valley_pulse, "R11", "collision valley seen", valley_pulse, 1);
    window(n, hi, np);
    chk(n == 16, "R11", "old period transferred", n, 16);
    window(n, hi, np);
    chk(n == 10, "R11", "new period next valley", n, 10);

    // R10 freeze
    repeat (3) @(negedge clk);
    cnt_en = 1'b0;
    c0 = cnt_out; p0 = pwm_out;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(cnt_out == c0, "R10", "count frozen", cnt_out, c0);
      chk(pwm_out == p0, "R10", "pwm frozen", pwm_out, p0);
      chk(!valley_pulse && !peak_pulse, "R10", "no pulse frozen", {valley_pulse, peak_pulse}, 0);
    end
    cnt_en = 1'b1;

    // R12 zero period
    do @(negedge clk); while (!valley_pulse);
    per_wr = 1'b1; per_wdata = 0;
    @(negedge clk);
    per_wr = 1'b0;
    while (!valley_pulse) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(cnt_out == 0 && valley_pulse, "R12", "hold at zero", cnt_out, 0);
      @(negedge clk);
    end
    per_wr = 1'b1; per_wdata = 3;
    @(negedge clk);
    per_wr = 1'b0;
    chk(cnt_out == 0 && valley_pulse, "R11", "zero still active", cnt_out, 0);
    @(negedge clk);
    chk(cnt_out == 1 && valley_pulse, "R12", "restart after reload", cnt_out, 1);
    window(n, hi, np);
    chk(n == 6, "R12", "cycle length P=3", n, 6);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end

endmodule